// File: doc/BRIEF.md
# Vector Predicate Mask Generator

This block turns compact predication fields into per-element enable masks for a vector loop. A single mode input chooses where the mask comes from. In integer mode, a 3-bit kind code selects one of three integer register values, or their complements, as a bit mask. The code can also select a one-hot mask indexed by the low bits of the first register, or "every element active". In condition mode, the same 3-bit code picks one of the four bits of each element's 4-bit condition field and optionally inverts it.

A second kind field produces an independent source mask when twin predication is enabled. A result test can also clear destination elements. It reads a selected bit, optionally inverted, from each element's result condition field. The condition-write mask is not affected by the result test, so the condition element is still written when the test fails. Every output bit at or above the vector length is zero. All outputs are registered.

Top module: `pmask_gen`

## Requirements
- R1: While rst_ni is low, dst_mask_o, src_mask_o and cond_wr_o are all zero.
- R2: Outputs change only on a rising clock edge and reflect the inputs sampled at that edge (one cycle of latency).
- R3: In integer mode (pred_cr_i=0), kind code 3'b000 makes every element below the vector length active.
- R4: In integer mode, kind 3'b110 makes element i active when bit i of ireg_c_i is 1, and kind 3'b111 makes it active when that bit is 0.
- R5: In integer mode, kind 3'b001 activates only the element whose index equals ireg_a_i[5:0]. Kinds 3'b010/3'b011 use bit i of ireg_a_i set/clear. Kinds 3'b100/3'b101 use bit i of ireg_b_i set/clear.
- R6: In condition mode (pred_cr_i=1), kind bits [2:1] select bit b of element i's field crf_i[4i+3:4i], and element i is active when crf_i[4i+b] XOR kind[0] is 1.
- R7: Bits of every output at index i >= vl_i are zero. A vl_i of 64 or more leaves every element eligible.
- R8: With twin_en_i=1, src_mask_o is decoded from src_kind_i under the same mode and rules. With twin_en_i=0, src_mask_o equals the destination mask before the result test.
- R9: With res_en_i=1, destination element i is cleared unless res_crf_i[4i+res_sel_i] XOR res_inv_i is 1. src_mask_o is not affected by the result test.
- R10: With wr_cond_i=1, cond_wr_o equals the destination mask before the result test. With wr_cond_i=0 it is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_cr_i | input | 1 | 1: condition-field predication, 0: integer predication |
| twin_en_i | input | 1 | Enable independent source mask |
| dst_kind_i | input | 3 | Destination mask kind code |
| src_kind_i | input | 3 | Source mask kind code |
| ireg_a_i | input | 64 | Integer register for kinds 001-011 |
| ireg_b_i | input | 64 | Integer register for kinds 100-101 |
| ireg_c_i | input | 64 | Integer register for kinds 110-111 |
| crf_i | input | 256 | Per-element 4-bit condition fields for predication |
| vl_i | input | 7 | Vector length |
| res_en_i | input | 1 | Enable result-based predication |
| res_sel_i | input | 2 | Result condition bit to test |
| res_inv_i | input | 1 | Invert the result test |
| res_crf_i | input | 256 | Per-element 4-bit result condition fields |
| wr_cond_i | input | 1 | Condition result writes requested |
| dst_mask_o | output | 64 | Destination predicate mask |
| src_mask_o | output | 64 | Source predicate mask |
| cond_wr_o | output | 64 | Condition-element write mask |

## Verification
Every output is due exactly one rising edge after the inputs that produce it, because a single register stage sits between the decode logic and the ports. The bench holds each stimulus across one rising edge. It compares all three masks with its reference at the following falling edge. It checks latency once directly: it changes an input just after a falling edge and confirms the outputs still hold the previous result before the next rising edge.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
  localparam int unsigned KIND_W = 3;
  localparam int unsigned COND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    K_ALL    = 3'b000,
    K_ONEHOT = 3'b001,
    K_A_SET  = 3'b010,
    K_A_CLR  = 3'b011,
    K_B_SET  = 3'b100,
    K_B_CLR  = 3'b101,
    K_C_SET  = 3'b110,
    K_C_CLR  = 3'b111
  } int_kind_e;
endpackage

// File: rtl/pmask_len.sv
module pmask_len #(
  parameter int unsigned N   = 64,
  parameter int unsigned VLW = $clog2(N + 1)
) (
  input  logic [VLW-1:0] vl_i,
  output logic [N-1:0]   len_o
);
  for (genvar g = 0; g < N; g++) begin : g_len
    assign len_o[g] = (vl_i > VLW'(g));
  end
endmodule

// File: rtl/pmask_decode.sv
module pmask_decode
  import pmask_pkg::*;
#(
  parameter int unsigned N    = 64,
  parameter int unsigned XLEN = 64,
  parameter int unsigned CRW  = COND_W,
  localparam int unsigned IW  = $clog2(N)
) (
  input  logic              mode_cr_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [XLEN-1:0]   reg_a_i,
  input  logic [XLEN-1:0]   reg_b_i,
  input  logic [XLEN-1:0]   reg_c_i,
  input  logic [N*CRW-1:0]  crf_i,
  output logic [N-1:0]      mask_o
);
  logic [N-1:0]  cr_m, hot_m, int_m;
  logic [IW-1:0] idx;

  assign idx = reg_a_i[IW-1:0];

  for (genvar g = 0; g < N; g++) begin : g_elem
    logic [CRW-1:0] fld;
    assign fld      = crf_i[g*CRW +: CRW];
    assign cr_m[g]  = fld[kind_i[2:1]] ^ kind_i[0];
    assign hot_m[g] = (idx == IW'(g));
  end

  always_comb begin
    unique case (int_kind_e'(kind_i))
      K_ALL:    int_m = '1;
      K_ONEHOT: int_m = hot_m;
      K_A_SET:  int_m = reg_a_i[N-1:0];
      K_A_CLR:  int_m = ~reg_a_i[N-1:0];
      K_B_SET:  int_m = reg_b_i[N-1:0];
      K_B_CLR:  int_m = ~reg_b_i[N-1:0];
      K_C_SET:  int_m = reg_c_i[N-1:0];
      K_C_CLR:  int_m = ~reg_c_i[N-1:0];
      default:  int_m = '1;
    endcase
  end

  assign mask_o = mode_cr_i ? cr_m : int_m;
endmodule

// File: rtl/pmask_result.sv
module pmask_result #(
  parameter int unsigned N   = 64,
  parameter int unsigned CRW = 4
) (
  input  logic [N*CRW-1:0] res_crf_i,
  input  logic [1:0]       sel_i,
  input  logic             inv_i,
  output logic [N-1:0]     pass_o
);
  for (genvar g = 0; g < N; g++) begin : g_test
    logic [CRW-1:0] fld;
    assign fld       = res_crf_i[g*CRW +: CRW];
    assign pass_o[g] = fld[sel_i] ^ inv_i;
  end
endmodule

// File: rtl/pmask_gen.sv
module pmask_gen
  import pmask_pkg::*;
#(
  parameter int unsigned N    = 64,
  parameter int unsigned XLEN = 64,
  parameter int unsigned CRW  = COND_W,
  localparam int unsigned VLW = $clog2(N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_cr_i,
  input  logic              twin_en_i,
  input  logic [KIND_W-1:0] dst_kind_i,
  input  logic [KIND_W-1:0] src_kind_i,
  input  logic [XLEN-1:0]   ireg_a_i,
  input  logic [XLEN-1:0]   ireg_b_i,
  input  logic [XLEN-1:0]   ireg_c_i,
  input  logic [N*CRW-1:0]  crf_i,
  input  logic [VLW-1:0]    vl_i,
  input  logic              res_en_i,
  input  logic [1:0]        res_sel_i,
  input  logic              res_inv_i,
  input  logic [N*CRW-1:0]  res_crf_i,
  input  logic              wr_cond_i,
  output logic [N-1:0]      dst_mask_o,
  output logic [N-1:0]      src_mask_o,
  output logic [N-1:0]      cond_wr_o
);
  logic [N-1:0] len_m, pass_m;
  logic [N-1:0] raw_m [2];
  logic [N-1:0] dst_pre, src_nxt, dst_nxt, cw_nxt;
  logic [KIND_W-1:0] kinds [2];

  assign kinds[0] = dst_kind_i;
  assign kinds[1] = src_kind_i;

  pmask_len #(.N(N), .VLW(VLW)) u_len (
    .vl_i  (vl_i),
    .len_o (len_m)
  );

  // slot 0 decodes the destination field, slot 1 the source field
  for (genvar s = 0; s < 2; s++) begin : g_dec
    pmask_decode #(.N(N), .XLEN(XLEN), .CRW(CRW)) u_dec (
      .mode_cr_i (pred_cr_i),
      .kind_i    (kinds[s]),
      .reg_a_i   (ireg_a_i),
      .reg_b_i   (ireg_b_i),
      .reg_c_i   (ireg_c_i),
      .crf_i     (crf_i),
      .mask_o    (raw_m[s])
    );
  end

  pmask_result #(.N(N), .CRW(CRW)) u_res (
    .res_crf_i (res_crf_i),
    .sel_i     (res_sel_i),
    .inv_i     (res_inv_i),
    .pass_o    (pass_m)
  );

  assign dst_pre = raw_m[0] & len_m;
  assign src_nxt = twin_en_i ? (raw_m[1] & len_m) : dst_pre;
  assign dst_nxt = res_en_i ? (dst_pre & pass_m) : dst_pre;
  // condition writes ignore the result test
  assign cw_nxt  = wr_cond_i ? dst_pre : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_mask_o <= '0;
      src_mask_o <= '0;
      cond_wr_o  <= '0;
    end else begin
      dst_mask_o <= dst_nxt;
      src_mask_o <= src_nxt;
      cond_wr_o  <= cw_nxt;
    end
  end
endmodule

// File: rtl/pmask_chk.sv
module pmask_chk #(
  parameter int unsigned N    = 64,
  parameter int unsigned XLEN = 64,
  parameter int unsigned CRW  = 4,
  localparam int unsigned VLW = $clog2(N + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           pred_cr_i,
  input logic           twin_en_i,
  input logic [2:0]     dst_kind_i,
  input logic [2:0]     src_kind_i,
  input logic [VLW-1:0] vl_i,
  input logic           res_en_i,
  input logic           wr_cond_i,
  input logic [N-1:0]   dst_mask_o,
  input logic [N-1:0]   src_mask_o,
  input logic [N-1:0]   cond_wr_o
);
  logic primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  function automatic logic [N-1:0] upto(input logic [VLW-1:0] v);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = (i < int'(v));
    return m;
  endfunction

  p_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q |-> (((dst_mask_o | src_mask_o | cond_wr_o) & ~upto($past(vl_i))) == '0));

  p_twin_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && !$past(twin_en_i) && !$past(res_en_i) |-> src_mask_o == dst_mask_o);

  p_res_within_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(wr_cond_i) |-> (dst_mask_o & ~cond_wr_o) == '0);

  p_cond_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && !$past(wr_cond_i) |-> cond_wr_o == '0);

  p_all_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && !$past(pred_cr_i) && ($past(dst_kind_i) == 3'b000) && !$past(res_en_i)
    |-> dst_mask_o == upto($past(vl_i)));

  p_complement_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && $past(twin_en_i) && !$past(pred_cr_i) && !$past(res_en_i)
    && ($past(dst_kind_i) == 3'b110) && ($past(src_kind_i) == 3'b111)
    |-> (dst_mask_o ^ src_mask_o) == upto($past(vl_i)));
endmodule

bind pmask_gen pmask_chk #(.N(N), .XLEN(XLEN), .CRW(CRW)) u_chk (.*);

// File: tb/tb_pmask_gen.sv
`timescale 1ns/1ps
module tb_pmask_gen;
  localparam int N = 64;
  localparam int CYCLES_MAX = 200000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pred_cr = 1'b0, twin_en = 1'b0, res_en = 1'b0, res_inv = 1'b0, wr_cond = 1'b0;
  logic [2:0]   dst_kind = 3'b000, src_kind = 3'b000;
  logic [63:0]  ra = '0, rb = '0, rcv = '0;
  logic [255:0] crf = '0, rcrf = '0;
  logic [6:0]   vl = 7'd64;
  logic [1:0]   res_sel = 2'd0;
  logic [63:0]  dst_m, src_m, cw_m;
  logic [63:0]  e_dst, e_src, e_cw;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  pmask_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .pred_cr_i(pred_cr), .twin_en_i(twin_en),
    .dst_kind_i(dst_kind), .src_kind_i(src_kind), .ireg_a_i(ra), .ireg_b_i(rb),
    .ireg_c_i(rcv), .crf_i(crf), .vl_i(vl), .res_en_i(res_en), .res_sel_i(res_sel),
    .res_inv_i(res_inv), .res_crf_i(rcrf), .wr_cond_i(wr_cond),
    .dst_mask_o(dst_m), .src_mask_o(src_m), .cond_wr_o(cw_m)
  );

  function automatic logic [63:0] ref_mask(input logic cr, input logic [2:0] k);
    logic [63:0] m;
    for (int i = 0; i < N; i++) begin
      logic b;
      if (cr) b = crf[i*4 + int'(k[2:1])] ^ k[0];
      else begin
        case (k)
          3'd0: b = 1'b1;
          3'd1: b = (int'(ra[5:0]) == i);
          3'd2: b = ra[i];
          3'd3: b = !ra[i];
          3'd4: b = rb[i];
          3'd5: b = !rb[i];
          3'd6: b = rcv[i];
          default: b = !rcv[i];
        endcase
      end
      m[i] = b && (i < int'(vl));
    end
    return m;
  endfunction

  task automatic compute_exp();
    logic [63:0] pre;
    pre   = ref_mask(pred_cr, dst_kind);
    e_src = twin_en ? ref_mask(pred_cr, src_kind) : pre;
    e_dst = pre;
    if (res_en)
      for (int i = 0; i < N; i++)
        if ((rcrf[i*4 + int'(res_sel)] ^ res_inv) == 1'b0) e_dst[i] = 1'b0;
    e_cw  = wr_cond ? pre : 64'd0;
  endtask

  task automatic cmp(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // inputs are set before the call; sample at the falling edge after one rising edge
  task automatic run(input string tag);
    compute_exp();
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "dst", dst_m, e_dst);
    cmp(tag, "src", src_m, e_src);
    cmp(tag, "cond", cw_m, e_cw);
  endtask

  initial begin
    #(4.0 * CYCLES_MAX);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    ra  = 64'h0123_4567_89AB_CD25;
    rb  = 64'hF0F0_1234_5678_9ABC;
    rcv = 64'hDEAD_BEEF_0F1E_2D3C;
    for (int i = 0; i < N; i++) begin
      crf[i*4 +: 4]  = 4'((i * 7 + 3) & 15);
      rcrf[i*4 +: 4] = 4'((i * 5 + 9) & 15);
    end
    wr_cond = 1'b1;
    // R1: outputs held at zero during reset
    repeat (3) @(negedge clk);
    cmp("R1", "dst", dst_m, 64'd0);
    cmp("R1", "src", src_m, 64'd0);
    cmp("R1", "cond", cw_m, 64'd0);
    rst_n = 1'b1;

    // R3: all active
    dst_kind = 3'b000; run("R3");
    // R4: register c set/clear, with twin giving the complement
    twin_en = 1'b1; dst_kind = 3'b110; src_kind = 3'b111; run("R4");
    dst_kind = 3'b111; src_kind = 3'b110; run("R4");
    // R5: remaining integer kinds
    twin_en = 1'b0;
    for (int k = 1; k <= 5; k++) begin dst_kind = 3'(k); run("R5"); end
    ra[5:0] = 6'd63; dst_kind = 3'b001; run("R5");
    // R6: condition mode, every bit select and inversion
    pred_cr = 1'b1;
    for (int k = 0; k < 8; k++) begin dst_kind = 3'(k); run("R6"); end
    // R7: vector length boundaries
    pred_cr = 1'b0; dst_kind = 3'b000;
    vl = 7'd0;  run("R7");
    vl = 7'd1;  run("R7");
    vl = 7'd37; dst_kind = 3'b110; run("R7");
    vl = 7'd63; run("R7");
    vl = 7'd100; dst_kind = 3'b000; run("R7");
    vl = 7'd64;
    // R8: twin on in both modes, then off
    twin_en = 1'b1; dst_kind = 3'b010; src_kind = 3'b101; run("R8");
    pred_cr = 1'b1; dst_kind = 3'b011; src_kind = 3'b100; run("R8");
    twin_en = 1'b0; run("R8");
    // R9: result test, each select and inversion
    pred_cr = 1'b0; dst_kind = 3'b000; res_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      res_sel = 2'(s); res_inv = 1'b0; run("R9");
      res_inv = 1'b1; run("R9");
    end
    twin_en = 1'b1; src_kind = 3'b110; dst_kind = 3'b100; vl = 7'd45; run("R9");
    // R10: condition writes off, and on with a failing test
    wr_cond = 1'b0; run("R10");
    wr_cond = 1'b1; res_sel = 2'd2; res_inv = 1'b0; run("R10");
    // R2: input change before a rising edge leaves outputs unchanged
    res_en = 1'b0; twin_en = 1'b0; vl = 7'd64; dst_kind = 3'b000; run("R2");
    dst_kind = 3'b110;
    #1;
    cmp("R2", "dst held", dst_m, 64'hFFFF_FFFF_FFFF_FFFF);
    run("R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule